// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models the target side of a two-wire serial EEPROM inside a larger chip. SCL and SDA arrive already synchronised to the system clock. The block drives a single open-drain enable (`sda_oe`, high means "pull SDA low") for acknowledge bits and read data. It decodes START and STOP. It matches a 7-bit device address whose two lowest bits come from strap inputs, so four such targets can share one bus. After a device address in write direction it takes two word-address bytes and then any number of data bytes.

Incoming data bytes collect in a page buffer. Nothing reaches the storage array until the STOP that ends the transaction. That STOP starts a self-timed internal write cycle whose length is a parameter in system clock cycles. The staged bytes drain into the array during this cycle, and the device ignores its own address until the cycle ends.

Reads come in three forms: from the persistent address counter, as a random read (two address bytes, a repeated START, then a read), or as a sequential stream that runs through the whole array. The default depth is small for simulation. Setting `ADDR_W` to 15 gives the full 32,768 bytes, arranged as 512 rows of 64 bytes.

Top module: `i2cee_target`

## Requirements
- R1: The device acknowledges an address byte only when its upper seven bits equal binary 1010, then 0, then `strap_i[1]`, then `strap_i[0]`. Bit 0 of that byte is the direction (1 = read). For any other address byte, `sda_oe` stays low for the rest of the transaction.
- R2: In write direction, the first byte after the device address carries the high word-address bits and the second carries the low 8 bits. Bits of the high byte above `ADDR_W-9` are ignored. Both bytes are acknowledged.
- R3: Each write data byte is acknowledged. After each byte only the low `PAGE_W` (default 6) address bits advance, so a write past the end of a row continues at the start of the same row and overwrites bytes sent earlier in that transaction.
- R4: Written bytes reach the storage array only through the internal write cycle, which starts at the STOP ending a write that carried at least one accepted data byte. Partial rows leave the other bytes of the row unchanged.
- R5: While the internal write cycle runs (`WCYC` clock cycles), the device acknowledges no address byte and never asserts `sda_oe`.
- R6: While `wp_i` is high, address and data bytes are still acknowledged, but the storage is unchanged and no internal write cycle starts, so the device answers its address right after the STOP.
- R7: The address counter holds the last accessed address plus one across transactions, and a read without address bytes starts there.
- R8: A random read consists of a write-direction address phase, a repeated START and a read-direction address byte. It returns data starting at the address just sent.
- R9: Sequential reads advance the full `ADDR_W`-bit address after each byte and continue from the last byte of the array to byte 0.
- R10: When the master does not acknowledge a read byte, the device releases SDA and drives nothing more until the next START.
- R11: A START or STOP in the middle of a byte aborts the transaction and leaves the address counter unchanged.
- R12: `sda_oe` is low after reset and is only asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock, synchronised |
| sda_i | input | 1 | Serial data as seen on the wire, synchronised |
| strap_i | input | 2 | Device address strap bits |
| wp_i | input | 1 | Write protect, high blocks storage updates |
| sda_oe | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
The hardest conditions to reach from the pins are the row wrap inside a single write and the wrap of a sequential read from the last byte to byte 0. The bench fills the whole reduced array row by row and then streams all of it back in one read so that the counter wraps. It also sends a 70-byte write that starts four bytes before a row end, so the last bytes of that write overwrite its first bytes. The mid-byte aborts are reached by calling the bit-level master tasks directly: the bench stops after three or four bits and issues a STOP or START, then reads from the current address to show that the counter did not move.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  // Bus engine states
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } bus_st_t;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    K_DEV,
    K_HI,
    K_LO,
    K_DATA
  } rx_kind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  function automatic rx_kind_t kind_after(input rx_kind_t k);
    case (k)
      K_DEV:   kind_after = K_HI;
      K_HI:    kind_after = K_LO;
      default: kind_after = K_DATA;
    endcase
  endfunction
endpackage

// File: rtl/i2cee_busmon.sv
module i2cee_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2cee_target.sv
module i2cee_target #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6,
  parameter int WCYC   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  import i2cee_pkg::*;

  localparam int PAGE_B = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WCYC + 1);
  localparam int CI_W   = PAGE_W + 1;

  // Address arithmetic
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    page_next = {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    seq_next = a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [7:0] hi, input logic [7:0] lo);
    join_addr = ADDR_W'({hi, lo});
  endfunction

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cee_busmon u_busmon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  bus_st_t            st;
  rx_kind_t           kind;
  logic [3:0]         bitcnt;
  logic [7:0]         sh;
  logic [6:0]         txb;
  logic               rd;
  logic [7:0]         addr_hi;
  logic [ADDR_W-1:0]  ptr;
  logic [7:0]         pbuf [PAGE_B];
  logic [PAGE_B-1:0]  pmask;
  logic [ROW_W-1:0]   prow;
  logic [CNT_W-1:0]   wcnt;
  logic [CI_W-1:0]    cidx;
  logic [7:0]         rdata;

  // Named internal events
  logic busy, byte_done, dev_hit, data_ev, tx_load_ev, commit_we;
  assign busy       = (wcnt != '0);
  assign byte_done  = (st == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign dev_hit    = (sh[7:1] == {DEV_TYPE, 1'b0, strap_i});
  assign data_ev    = byte_done && (kind == K_DATA);
  assign tx_load_ev = scl_fall && (((st == S_ACK) && (kind == K_DEV) && rd) || (st == S_MACK));
  assign commit_we  = busy && !cidx[PAGE_W] && pmask[cidx[PAGE_W-1:0]];

  i2cee_store #(.ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (commit_we),
    .waddr ({prow, cidx[PAGE_W-1:0]}),
    .wdata (pbuf[cidx[PAGE_W-1:0]]),
    .raddr (ptr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (data_ev && !wp_i) pbuf[ptr[PAGE_W-1:0]] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_DEV;
      bitcnt  <= '0;
      sh      <= '0;
      txb     <= '0;
      rd      <= 1'b0;
      addr_hi <= '0;
      ptr     <= '0;
      pmask   <= '0;
      prow    <= '0;
      wcnt    <= '0;
      cidx    <= {1'b1, {PAGE_W{1'b0}}};
      sda_oe  <= 1'b0;
    end else begin
      // self-timed write cycle: drain one staged slot per clock
      if (busy) begin
        wcnt <= wcnt - CNT_W'(1);
        if (!cidx[PAGE_W]) begin
          pmask[cidx[PAGE_W-1:0]] <= 1'b0;
          cidx <= cidx + CI_W'(1);
        end
      end

      if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (!busy && (pmask != '0)) begin
          wcnt <= CNT_W'(WCYC);
          cidx <= '0;
        end
      end else if (start_ev) begin
        st     <= S_RX;
        kind   <= K_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (!busy) pmask <= '0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              st     <= S_ACK;
              sda_oe <= 1'b1;
              case (kind)
                K_DEV: begin
                  rd <= sh[0];
                  if (!(dev_hit && !busy)) begin
                    st     <= S_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                K_HI: addr_hi <= sh;
                K_LO: ptr <= join_addr(addr_hi, sh);
                default: begin
                  if (!wp_i) pmask[ptr[PAGE_W-1:0]] <= 1'b1;
                  prow <= ptr[ADDR_W-1:PAGE_W];
                  ptr  <= page_next(ptr);
                end
              endcase
            end
          end
          S_ACK: begin
            if (tx_load_ev) begin
              txb    <= rdata[6:0];
              sda_oe <= ~rdata[7];
              bitcnt <= 4'd1;
              ptr    <= seq_next(ptr);
              st     <= S_TX;
            end else if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= S_RX;
              bitcnt <= '0;
              kind   <= kind_after(kind);
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~txb[6];
                txb    <= {txb[5:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise && sda_i) begin
              st <= S_IDLE;
            end else if (tx_load_ev) begin
              txb    <= rdata[6:0];
              sda_oe <= ~rdata[7];
              bitcnt <= 4'd1;
              ptr    <= seq_next(ptr);
              st     <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Assertions
  p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_wp_no_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ev && wp_i) |=> $stable(pmask));

  p_row_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_ev |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_ev |=> (ptr == $past(ptr) + ADDR_W'(1)));

  p_abort_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> $stable(ptr));

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

// File: tb/i2cee_target_bench.sv
module i2cee_target_bench;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int WC = 100;
  localparam logic [7:0] DW = 8'hA4;
  localparam logic [7:0] DR = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2cee_target #(.ADDR_W(AW), .PAGE_W(6), .WCYC(WC)) u_i2cee_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (3) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = !sda_line;
    scl_m = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); d[i] = sda_line; scl_m = 1'b0;
    end
    sda_m = !mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] gen(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + 5) ^ (a >> 3));
  endfunction

  task automatic send_addr(input int addr, input string tag);
    bit ack;
    wbyte(8'hB6 | 8'((addr >> 8) & 1), ack); chk(ack, tag, ack, 1);
    wbyte(8'(addr & 255), ack); chk(ack, tag, ack, 1);
  endtask

  // R3: row-wrapping page write; model follows only when wp low
  task automatic wr(input int addr, input int n, input int seed);
    bit ack;
    bstart();
    wbyte(DW, ack); chk(ack, "R1", ack, 1);
    send_addr(addr, "R2");
    for (int i = 0; i < n; i++) begin
      int a;
      a = (addr & ~63) | ((addr + i) & 63);
      wbyte(gen(i, seed), ack); chk(ack, "R3", ack, 1);
      if (!wp) model[a] = gen(i, seed);
    end
    bstop();
  endtask

  task automatic read_n(input int first, input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (first + i) % DEPTH;
      rbyte(d, i < n - 1);
      chk(d == model[a], tag, d, model[a]);
    end
    hp();
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
  endtask

  task automatic rd_rand(input int addr, input int n, input string tag);
    bit ack;
    bstart(); wbyte(DW, ack); chk(ack, "R8", ack, 1);
    send_addr(addr, "R2");
    bstart(); wbyte(DR, ack); chk(ack, "R8", ack, 1);
    read_n(addr, n, tag);
    bstop();
  endtask

  task automatic rd_cur(input int first, input int n, input string tag);
    bit ack;
    bstart(); wbyte(DR, ack); chk(ack, "R7", ack, 1);
    read_n(first, n, tag);
    bstop();
  endtask

  // R5: count nacked polls until the write cycle ends
  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    for (int k = 0; k < 50; k++) begin
      bstart(); wbyte(DW, ack); bstop();
      if (ack) break;
      polls++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R12: enable never changes while SCL stays high
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always begin
    @(negedge clk); #2;
    if (rst_n && sda_oe !== oe_prev && scl_m && scl_prev)
      chk(1'b0, "R12", sda_oe, oe_prev);
    oe_prev = sda_oe;
    scl_prev = scl_m;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    bit ack;
    int polls;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R12", sda_oe, 0);
    rst_n = 1'b1;
    hp();

    // R1: every write-direction device address, only 1010_0_10 answers
    for (int a = 0; a < 128; a++) begin
      bstart(); wbyte({7'(a), 1'b0}, ack); bstop();
      chk(ack == (a == 7'h52), "R1", ack, a == 7'h52);
    end

    // R4/R5: fill every row, then poll through the write cycle
    for (int p = 0; p < DEPTH / 64; p++) begin
      wr(p * 64, 64, p);
      wait_ready(polls);
      chk(polls >= 1 && polls <= 3, "R5", polls, 1);
    end

    // R4/R9: stream the whole array, then continue past the end
    rd_rand(0, DEPTH, "R4");
    rd_cur(0, 3, "R9");
    rd_rand(DEPTH - 4, 8, "R9");

    // R3: 70 bytes from 4 before row end overwrite the first ones
    wr(3 * 64 + 60, 70, 9);
    wait_ready(polls);
    chk(polls >= 1, "R5", polls, 1);
    rd_cur(3 * 64 + 2, 2, "R7");
    rd_rand(3 * 64, 64, "R3");

    // R4: partial row write leaves neighbours alone
    wr(5 * 64 + 10, 3, 4);
    wait_ready(polls);
    rd_rand(5 * 64 + 8, 7, "R4");

    // R6: write protect
    wp = 1'b1;
    wr(6 * 64, 5, 12);
    bstart(); wbyte(DW, ack); bstop();
    chk(ack, "R6", ack, 1);
    wp = 1'b0;
    rd_rand(6 * 64, 5, "R6");

    // R11: STOP after three bits of the low address byte
    rd_rand(100, 1, "R8");
    bstart(); wbyte(DW, ack); wbyte(8'h00, ack);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bstop();
    rd_cur(101, 1, "R11");
    // R11: START after four bits, then current read
    bstart(); wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    bstart(); wbyte(DR, ack); chk(ack, "R11", ack, 1);
    rbyte(d, 1'b0);
    chk(d == model[102], "R11", d, model[102]);
    // R10: after the NACK the device drives nothing
    rbyte(d, 1'b0);
    chk(d == 8'hFF, "R10", d, 255);
    bstop();

    done = 1;
    finish_run();
  end
endmodule